// File: doc/BRIEF.md
# Stepping ALU with Zero Flag

This block is a purely combinational arithmetic unit for a microcoded datapath. It takes two operand words and an operation code, and it returns one result word and a flag that is high whenever that result is all zeros. The microcode sequencer reads the flag to decide conditional branches.

The operation set covers passing either operand through unchanged, adding or subtracting a small or a large fixed step on operand A, full addition and subtraction, and signed and unsigned less-than comparison. The fixed steps let microcode move a program counter without first loading a constant into operand B. The block has no clock, no reset and no stored state.

The word width, the two step sizes and the style of the magnitude comparator are parameters. Elaboration-time checks reject values that make no sense for them.

Top module: `ustep_alu`

## Requirements
- R1: Operation code 0 (pass A) gives result = A, and code 1 (pass B) gives result = B.
- R2: Code 2 gives A+1 and code 3 gives A-1, both wrapping modulo 2^WIDTH.
- R3: Code 4 gives A+4 and code 5 gives A-4, both wrapping modulo 2^WIDTH.
- R4: Code 6 gives A+B and code 7 gives A-B, both wrapping modulo 2^WIDTH. No overflow indication exists.
- R5: Code 8 gives 1 when A < B as two's-complement signed numbers and 0 otherwise. The value is zero-extended to the full width.
- R6: Code 9 gives 1 when A < B as unsigned numbers and 0 otherwise. The value is zero-extended to the full width.
- R7: The zero flag is 1 exactly when every bit of the result is 0. For example, code 7 with A=2 and B=2 gives a flag of 1.
- R8: Codes 10 through 15 give a result of 0, so the flag is 1 for them.
- R9: The outputs follow any change of the inputs with no clock edge, and they depend only on the current inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0..9 defined, 10..15 unused) |
| opnd_a | input | WIDTH (32) | Operand A |
| opnd_b | input | WIDTH (32) | Operand B |
| result | output | WIDTH (32) | Operation result |
| zero_flag | output | 1 | High when result is all zeros |

## Verification
The assertions assume that all inputs carry known two-valued levels, and they are evaluated whenever the inputs settle. There is no handshake or hold condition on the inputs. The stimulus drives only fully defined values. It draws random operands that are biased toward small magnitudes, equal pairs and sign-boundary words, so that the comparisons, wraparounds and zero results all occur often. Every one of the sixteen operation codes, including the unused ones, is applied.

// File: rtl/ustep_alu_pkg.sv
package ustep_alu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_PASS_A = 4'd0,
      OP_PASS_B = 4'd1,
      OP_INC_S  = 4'd2,
      OP_DEC_S  = 4'd3,
      OP_INC_L  = 4'd4,
      OP_DEC_L  = 4'd5,
      OP_ADD    = 4'd6,
      OP_SUB    = 4'd7,
      OP_LT_S   = 4'd8,
      OP_LT_U   = 4'd9
   } alu_op_e;

   // comparator implementation choice
   localparam int CMP_NATIVE = 0;
   localparam int CMP_RIPPLE = 1;
endpackage

// File: rtl/ustep_alu_addsub.sv
// Shared adder: A plus or minus a selected second operand.
module ustep_alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] k_in,
   input  logic             sub_en,
   output logic [WIDTH-1:0] sum_out
);
   logic [WIDTH-1:0] k_eff;

   always_comb begin
      k_eff   = sub_en ? ~k_in : k_in;
      sum_out = a_in + k_eff + {{(WIDTH-1){1'b0}}, sub_en};
   end
endmodule

// File: rtl/ustep_alu_cmp.sv
// Magnitude comparator, signed and unsigned, two build variants.
module ustep_alu_cmp
   import ustep_alu_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int CMP_STYLE = CMP_NATIVE
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic             lt_s,
   output logic             lt_u
);
   localparam int MSB = WIDTH - 1;

   generate
      if (CMP_STYLE == CMP_RIPPLE) begin : g_ripple
         logic [WIDTH:0] brw;
         assign brw[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign brw[i+1] = (~a_in[i] & b_in[i]) |
                              (~(a_in[i] ^ b_in[i]) & brw[i]);
         end
         assign lt_u = brw[WIDTH];
      end else begin : g_native
         assign lt_u = (a_in < b_in);
      end
   endgenerate

   // Equal signs: unsigned order matches signed order.
   assign lt_s = (a_in[MSB] ^ b_in[MSB]) ? a_in[MSB] : lt_u;
endmodule

// File: rtl/ustep_alu_zdet.sv
// All-zero detector over the result word.
module ustep_alu_zdet #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] word_in,
   output logic             is_zero
);
   assign is_zero = ~|word_in;
endmodule

// File: rtl/ustep_alu.sv
module ustep_alu
   import ustep_alu_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int STEP_S    = 1,
   parameter int STEP_L    = 4,
   parameter int CMP_STYLE = CMP_NATIVE
) (
   input  logic [OP_W-1:0]  op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] result,
   output logic             zero_flag
);
   localparam logic [WIDTH-1:0] K_S = WIDTH'(STEP_S);
   localparam logic [WIDTH-1:0] K_L = WIDTH'(STEP_L);

   generate
      if (WIDTH < 8) begin : g_bad_width
         $error("ustep_alu: WIDTH must be at least 8");
      end
      if (STEP_S < 1 || STEP_L <= STEP_S || STEP_L > 255) begin : g_bad_step
         $error("ustep_alu: need 1 <= STEP_S < STEP_L <= 255");
      end
      if (CMP_STYLE != CMP_NATIVE && CMP_STYLE != CMP_RIPPLE) begin : g_bad_cmp
         $error("ustep_alu: unknown CMP_STYLE");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] k_sel;
   logic             sub_en;
   logic [WIDTH-1:0] sum;
   logic             lt_s;
   logic             lt_u;

   assign op = alu_op_e'(op_sel);

   always_comb begin
      k_sel  = opnd_b;
      sub_en = 1'b0;
      unique case (op)
         OP_INC_S: k_sel = K_S;
         OP_DEC_S: begin k_sel = K_S; sub_en = 1'b1; end
         OP_INC_L: k_sel = K_L;
         OP_DEC_L: begin k_sel = K_L; sub_en = 1'b1; end
         OP_SUB:   sub_en = 1'b1;
         default:  ;
      endcase
   end

   ustep_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a_in   (opnd_a),
      .k_in   (k_sel),
      .sub_en (sub_en),
      .sum_out(sum)
   );

   ustep_alu_cmp #(.WIDTH(WIDTH), .CMP_STYLE(CMP_STYLE)) u_cmp (
      .a_in(opnd_a),
      .b_in(opnd_b),
      .lt_s(lt_s),
      .lt_u(lt_u)
   );

   always_comb begin
      case (op)
         OP_PASS_A: result = opnd_a;
         OP_PASS_B: result = opnd_b;
         OP_INC_S, OP_DEC_S, OP_INC_L, OP_DEC_L,
         OP_ADD, OP_SUB: result = sum;
         OP_LT_S:   result = {{(WIDTH-1){1'b0}}, lt_s};
         OP_LT_U:   result = {{(WIDTH-1){1'b0}}, lt_u};
         default:   result = '0;
      endcase
   end

   ustep_alu_zdet #(.WIDTH(WIDTH)) u_zdet (
      .word_in(result),
      .is_zero(zero_flag)
   );
endmodule

// File: rtl/ustep_alu_chk.sv
module ustep_alu_chk
   import ustep_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input logic [OP_W-1:0]  op_sel,
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [WIDTH-1:0] result,
   input logic             zero_flag
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      if (op_sel == 4'd0)
         p_pass_a_r1: assert (result == opnd_a) else $error("R1 pass A");
      if (op_sel == 4'd1)
         p_pass_b_r1: assert (result == opnd_b) else $error("R1 pass B");
      if (op_sel == 4'd2 || op_sel == 4'd3)
         p_step_s_r2: assert ((result - opnd_a == WIDTH'(1)) || (opnd_a - result == WIDTH'(1)))
            else $error("R2 small step");
      if (op_sel == 4'd4 || op_sel == 4'd5)
         p_step_l_r3: assert ((result - opnd_a == WIDTH'(4)) || (opnd_a - result == WIDTH'(4)))
            else $error("R3 large step");
      if (op_sel == 4'd7)
         p_no_overflow_r4: assert (result + opnd_b == opnd_a) else $error("R4 subtract");
      if (op_sel == 4'd8)
         p_lt_s_r5: assert (result[MSB:1] == '0 &&
                            result[0] == ($signed(opnd_a) < $signed(opnd_b)))
            else $error("R5 signed compare");
      if (op_sel == 4'd9)
         p_lt_u_r6: assert (result[MSB:1] == '0 && result[0] == (opnd_a < opnd_b))
            else $error("R6 unsigned compare");
      p_zero_r7: assert (zero_flag == (result == '0)) else $error("R7 zero flag");
      if (op_sel > 4'd9)
         p_unused_r8: assert (result == '0 && zero_flag) else $error("R8 unused code");
   end
endmodule

bind ustep_alu ustep_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/ustep_alu_bench.sv
`timescale 1ns/1ps
module ustep_alu_bench;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic [3:0]   op_sel = 4'd0;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic [W-1:0] result;
   logic         zero_flag;

   int checks = 0;
   int errors = 0;
   int edges  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) edges++;

   ustep_alu u_ustep_alu (
      .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .result(result), .zero_flag(zero_flag)
   );

   function automatic logic [W-1:0] model(input logic [3:0] op,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
      case (op)
         4'd0: return a;
         4'd1: return b;
         4'd2: return a + 32'd1;
         4'd3: return a - 32'd1;
         4'd4: return a + 32'd4;
         4'd5: return a - 32'd4;
         4'd6: return a + b;
         4'd7: return a - b;
         4'd8: return {31'd0, $signed(a) < $signed(b)};
         4'd9: return {31'd0, a < b};
         default: return '0;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd1: return "R1";
         4'd2, 4'd3: return "R2";
         4'd4, 4'd5: return "R3";
         4'd6, 4'd7: return "R4";
         4'd8:       return "R5";
         4'd9:       return "R6";
         default:    return "R8";
      endcase
   endfunction

   task automatic check_now(input string req);
      logic [W-1:0] exp_r;
      exp_r = model(op_sel, opnd_a, opnd_b);
      checks++;
      if (result !== exp_r) begin
         errors++;
         $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
                  req, op_sel, opnd_a, opnd_b, result, exp_r);
      end
      checks++;
      if (zero_flag !== (exp_r == '0)) begin
         errors++;
         $display("FAIL R7 op=%0d zero_flag actual=%b expected=%b",
                  op_sel, zero_flag, exp_r == '0);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      op_sel = op; opnd_a = a; opnd_b = b;
      #1;
      check_now(req_of(op));
   endtask

   function automatic logic [W-1:0] pick();
      case ($urandom_range(0, 5))
         0: return $urandom_range(0, 8);
         1: return 32'hFFFF_FFFF - $urandom_range(0, 8);
         2: return 32'h8000_0000 + $urandom_range(0, 4) - 2;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int start_edges;
      void'($urandom(32'd1357));
      // reset state: all-zero inputs, pass A -> 0, flag high
      #1; check_now("R1");

      // directed corners
      apply(4'd0, 32'hDEAD_BEEF, 32'h1234_5678);   // R1
      apply(4'd1, 32'hDEAD_BEEF, 32'h1234_5678);   // R1
      apply(4'd2, 32'hFFFF_FFFF, 32'd0);           // R2 wrap up to 0
      apply(4'd3, 32'd0, 32'd0);                   // R2 wrap down
      apply(4'd4, 32'hFFFF_FFFC, 32'd0);           // R3 wrap to 0
      apply(4'd5, 32'd2, 32'd0);                   // R3 wrap down
      apply(4'd6, 32'h7FFF_FFFF, 32'd1);           // R4 signed overflow, no flag
      apply(4'd7, 32'd2, 32'd2);                   // R4 and R7: zero result
      apply(4'd7, 32'h8000_0000, 32'd1);           // R4
      apply(4'd8, 32'h8000_0000, 32'd1);           // R5 negative < positive
      apply(4'd8, 32'd5, 32'd5);                   // R5 equal -> 0
      apply(4'd9, 32'd1, 32'h8000_0000);           // R6 unsigned less
      apply(4'd9, 32'hFFFF_FFFF, 32'd0);           // R6 not less
      for (int c = 10; c < 16; c++) apply(4'(c), 32'hFFFF_FFFF, 32'h1); // R8

      // R9: outputs track inputs between clock edges
      @(negedge clk);
      start_edges = edges;
      op_sel = 4'd6; opnd_a = 32'd10; opnd_b = 32'd20;
      #1; check_now("R9");
      opnd_b = 32'd30;
      #1; check_now("R9");
      op_sel = 4'd7; opnd_a = 32'd30;
      #1; check_now("R9");
      checks++;
      if (edges != start_edges) begin
         errors++;
         $display("FAIL R9 edges actual=%0d expected=%0d", edges, start_edges);
      end

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         logic [W-1:0] a, b;
         a = pick();
         b = ($urandom_range(0, 7) == 0) ? a : pick();
         apply(4'($urandom_range(0, 15)), a, b);
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule